// File: doc/BRIEF.md
# Clock Frequency Meter

This block measures the frequency of one of several monitored clocks against a free-running reference clock. The reference clock also clocks the register interface. Software sets a window length in reference cycles and picks a monitored channel. It turns on the reference free-run enable and then sets the start bit. For exactly the programmed number of reference cycles, a gate signal is held high. A single counter runs in the domain of the selected monitored clock and counts that clock's rising edges while its synchronized copy of the gate is high.

The monitored-domain gate is synchronized back into the reference domain and serves as an acknowledge. After the window, the reference side drops the gate and waits for the acknowledge to fall. At that point the monitored counter is frozen, so its value is latched into the result register and the valid flag is raised. The flag stays set until software clears the start bit or the free-run enable. Clearing either one returns the meter to idle, ready for a new run.

The reference-side controller has four states. ST_IDLE waits for a start. ST_COUNT keeps the gate high through the window. ST_DRAIN waits for the gate to settle in the monitored domain. ST_DONE holds the result and valid. The transitions are:
- idle to count: start set, free-run set, window non-zero and acknowledge low.
- count to drain: window elapsed and acknowledge high.
- drain to done: acknowledge low.
- any busy state to idle: start or free-run cleared.

Top module: `clk_freq_meter`

## Requirements
- R1: After reset, the control, result and monitor registers read 0, and any unmapped address reads 0.
- R2: The control register at address 0x00 holds the window length in bits 23:0, the start bit in bit 24 and the channel select in bits 27:26. These fields read back as written, and all other bits read 0.
- R3: The monitor register at address 0x10 has a read/write free-run enable at bit 8 and a read-only valid flag at bit 0. A write to bit 0 has no effect.
- R4: A completed measurement leaves, in the result register at 0x0C, the number of rising edges of the selected clock during the window. This is N·Tref/Tmon within ±3.
- R5: The channel select value k (0 to 3) routes monitored clock k, and only clock k, to the counter.
- R6: Valid rises only after a full window and a drain. It stays set, with a stable result, until the start bit or the free-run enable is cleared.
- R7: Clearing the start bit, during a run or after completion, drops valid on the next cycle. A later start counts from zero again.
- R8: With the free-run enable at 0, setting the start bit never produces valid.
- R9: With a window length of 0, setting the start bit never produces valid.
- R10: Valid is not set earlier than N reference cycles after the start bit is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, also clocks the register interface |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| mon_clk | input | N_CH | Monitored clocks, one per channel |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational from bus_addr) |

## Verification
All four channels are measured with full 1024-cycle windows. Their clock periods differ (3, 7, 11 and 20 ns), so a wrong select, a swapped channel or a miscounted edge each gives a distinct wrong count. A very short window of 8 cycles and a mid-length window show whether the count scales with the window length and whether the drain handshake still completes when the gate barely reaches the monitored side. A run is aborted part way and then restarted, and runs are attempted with the free-run enable off and with a zero window. These cases separate a meter that restarts cleanly from one that carries over stale counts or raises valid when it should not.

// File: rtl/fm_pkg.sv
package fm_pkg;

    localparam int unsigned BUS_AW = 5;
    localparam int unsigned BUS_DW = 32;

    localparam logic [BUS_AW-1:0] ADDR_CTRL   = 5'h00;
    localparam logic [BUS_AW-1:0] ADDR_RESULT = 5'h0C;
    localparam logic [BUS_AW-1:0] ADDR_MON    = 5'h10;

    localparam int unsigned CTRL_START_BIT = 24;
    localparam int unsigned CTRL_SEL_LSB   = 26;
    localparam int unsigned MON_FRUN_BIT   = 8;
    localparam int unsigned MON_VALID_BIT  = 0;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } fm_state_e;

endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/fm_regs.sv
module fm_regs
    import fm_pkg::*;
#(
    parameter int unsigned WIN_W = 24,
    parameter int unsigned SEL_W = 2,
    parameter int unsigned CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BUS_AW-1:0] addr,
    input  logic [BUS_DW-1:0] wdata,
    input  logic              valid,
    input  logic [CNT_W-1:0]  result,
    output logic [WIN_W-1:0]  win_len,
    output logic              start,
    output logic [SEL_W-1:0]  sel,
    output logic              frun_en,
    output logic [BUS_DW-1:0] rdata
);
    logic unused_wdata;
    assign unused_wdata = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_len <= '0;
            start   <= 1'b0;
            sel     <= '0;
            frun_en <= 1'b0;
        end else if (we) begin
            if (addr == ADDR_CTRL) begin
                win_len <= wdata[WIN_W-1:0];
                start   <= wdata[CTRL_START_BIT];
                sel     <= wdata[CTRL_SEL_LSB +: SEL_W];
            end
            if (addr == ADDR_MON) begin
                frun_en <= wdata[MON_FRUN_BIT];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_CTRL) begin
            rdata[WIN_W-1:0]             = win_len;
            rdata[CTRL_START_BIT]        = start;
            rdata[CTRL_SEL_LSB +: SEL_W] = sel;
        end else if (addr == ADDR_RESULT) begin
            rdata[CNT_W-1:0] = result;
        end else if (addr == ADDR_MON) begin
            rdata[MON_FRUN_BIT]  = frun_en;
            rdata[MON_VALID_BIT] = valid;
        end
    end
endmodule

// File: rtl/fm_mon_counter.sv
module fm_mon_counter #(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             mclk,
    input  logic             rst_n,
    input  logic             gate,
    output logic             gate_s,
    output logic [CNT_W-1:0] count
);
    logic gate_d;

    fm_sync #(.STAGES(STAGES)) u_gate_sync (
        .clk   (mclk),
        .rst_n (rst_n),
        .d     (gate),
        .q     (gate_s)
    );

    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            gate_d <= 1'b0;
            count  <= '0;
        end else begin
            gate_d <= gate_s;
            if (gate_s && !gate_d) begin
                count <= CNT_W'(1);
            end else if (gate_s) begin
                count <= count + CNT_W'(1);
            end
        end
    end

    // R4: each monitored edge inside an open gate adds exactly one
    a_r4_count_step: assert property (@(posedge mclk) disable iff (!rst_n)
        (gate_s && gate_d) |=> (count == $past(count) + CNT_W'(1)));

    // R7: a fresh gate always restarts the count from one
    a_r7_count_restart: assert property (@(posedge mclk) disable iff (!rst_n)
        (gate_s && !gate_d) |=> (count == CNT_W'(1)));
endmodule

// File: rtl/fm_ref_fsm.sv
module fm_ref_fsm
    import fm_pkg::*;
#(
    parameter int unsigned WIN_W  = 24,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             frun_en,
    input  logic [WIN_W-1:0] win_len,
    input  logic             ack_raw,
    input  logic [CNT_W-1:0] mon_count,
    output logic             gate,
    output logic             valid,
    output logic [CNT_W-1:0] result
);
    localparam int unsigned EW = WIN_W + 1;

    fm_state_e        state_q, state_d;
    logic [WIN_W-1:0] elapsed_q;
    logic             ack;
    logic             abort;
    logic             win_done;

    fm_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_raw),
        .q     (ack)
    );

    assign abort    = !start || !frun_en;
    assign win_done = ({1'b0, elapsed_q} + EW'(1)) >= {1'b0, win_len};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start && frun_en && (win_len != '0) && !ack) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (abort)                state_d = ST_IDLE;
                else if (win_done && ack) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (abort)     state_d = ST_IDLE;
                else if (!ack) state_d = ST_DONE;
            end
            ST_DONE: begin
                if (abort) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate      <= 1'b0;
            elapsed_q <= '0;
            result    <= '0;
        end else begin
            gate <= (state_d == ST_COUNT);
            if (state_d != ST_COUNT) begin
                elapsed_q <= '0;
            end else if (state_q == ST_COUNT && !win_done) begin
                elapsed_q <= elapsed_q + WIN_W'(1);
            end
            if (state_q == ST_DRAIN && state_d == ST_DONE) begin
                result <= mon_count;
            end
        end
    end

    assign valid = (state_q == ST_DONE);

    // R7: dropping the start bit returns any busy state to idle
    a_r7_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !start) |=> (state_q == ST_IDLE));

    // R8: valid appears only when the free-run enable and start were set
    a_r8_valid_needs_frun: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> ($past(frun_en) && $past(start)));

    // R9: a zero window never leaves idle
    a_r9_zero_window: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && win_len == '0) |=> (state_q == ST_IDLE));

    // R6: valid only follows a drain, and the result holds while valid
    a_r6_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> ($past(state_q) == ST_DRAIN));
    a_r6_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && $past(valid)) |-> $stable(result));
endmodule

// File: rtl/clk_freq_meter.sv
module clk_freq_meter
    import fm_pkg::*;
#(
    parameter int unsigned N_CH   = 4,
    parameter int unsigned WIN_W  = 24,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   mon_clk,
    input  logic              bus_we,
    input  logic [4:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    localparam int unsigned SEL_W = (N_CH > 1) ? $clog2(N_CH) : 1;

    logic [WIN_W-1:0] win_len;
    logic             start;
    logic [SEL_W-1:0] sel;
    logic             frun_en;
    logic             valid;
    logic [CNT_W-1:0] result;
    logic             gate;
    logic             gate_s;
    logic [CNT_W-1:0] mon_count;
    logic             mon_sel_clk;

    fm_regs #(.WIN_W(WIN_W), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .valid   (valid),
        .result  (result),
        .win_len (win_len),
        .start   (start),
        .sel     (sel),
        .frun_en (frun_en),
        .rdata   (bus_rdata)
    );

    assign mon_sel_clk = mon_clk[sel];

    fm_mon_counter #(.CNT_W(CNT_W), .STAGES(STAGES)) u_mon_cnt (
        .mclk   (mon_sel_clk),
        .rst_n  (rst_n),
        .gate   (gate),
        .gate_s (gate_s),
        .count  (mon_count)
    );

    fm_ref_fsm #(.WIN_W(WIN_W), .CNT_W(CNT_W), .STAGES(STAGES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .frun_en   (frun_en),
        .win_len   (win_len),
        .ack_raw   (gate_s),
        .mon_count (mon_count),
        .gate      (gate),
        .valid     (valid),
        .result    (result)
    );
endmodule

// File: tb/clk_freq_meter_tb_top.sv
`timescale 1ns/1ps
module clk_freq_meter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mon_clk = 4'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = 5'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;

    int n_checks = 0;
    int n_bad = 0;
    bit run_done = 1'b0;

    typedef struct {
        int    lo;
        int    hi;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   act_q[$];

    localparam int TREF_PS = 5000;
    int tmon_ps[4] = '{3000, 7000, 11000, 20000};

    always #2.5 clk = ~clk;
    always #1.5 mon_clk[0] = ~mon_clk[0];
    always #3.5 mon_clk[1] = ~mon_clk[1];
    always #5.5 mon_clk[2] = ~mon_clk[2];
    always #10  mon_clk[3] = ~mon_clk[3];

    clk_freq_meter dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mon_clk   (mon_clk),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b0;
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] ctrl_word(input int ch, input int n, input bit go);
        return (32'(ch) << 26) | (32'(go) << 24) | (32'(n) & 32'h00FF_FFFF);
    endfunction

    task automatic measure(input int ch, input int n, input string tag);
        logic [31:0] d;
        logic [31:0] r0;
        int polls;
        int ideal;
        exp_t e;
        bus_write(5'h10, 32'h100);
        bus_write(5'h00, ctrl_word(ch, n, 1'b0));
        bus_write(5'h00, ctrl_word(ch, n, 1'b1));
        polls = 0;
        d = '0;
        while (d[0] == 1'b0 && polls < 20000) begin
            bus_read(5'h10, d);
            polls++;
        end
        check(d[0] == 1'b1, "R6 valid reached", int'(d[0]), 1);
        check(polls >= n, "R10 no early valid", polls, n);
        bus_read(5'h0C, r0);
        ideal = (n * TREF_PS) / tmon_ps[ch];
        e.lo = ideal - 3;
        e.hi = ideal + 3;
        e.tag = tag;
        exp_q.push_back(e);
        act_q.push_back(int'(r0));
        repeat (20) @(negedge clk);
        bus_read(5'h10, d);
        check(d[0] == 1'b1, "R6 valid held", int'(d[0]), 1);
        bus_read(5'h0C, d);
        check(d == r0, "R6 result stable", int'(d), int'(r0));
        bus_write(5'h00, ctrl_word(ch, n, 1'b0));
        bus_read(5'h10, d);
        check(d[0] == 1'b0, "R7 clear drops valid", int'(d[0]), 0);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (act_q.size() > 0 && exp_q.size() > 0) begin
                exp_t e;
                int a;
                e = exp_q.pop_front();
                a = act_q.pop_front();
                check(a >= e.lo && a <= e.hi, e.tag, a, (e.lo + e.hi) / 2);
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!run_done) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state
        bus_read(5'h00, d); check(d == 32'h0, "R1 ctrl reset", int'(d), 0);
        bus_read(5'h0C, d); check(d == 32'h0, "R1 result reset", int'(d), 0);
        bus_read(5'h10, d); check(d == 32'h0, "R1 monitor reset", int'(d), 0);
        bus_read(5'h04, d); check(d == 32'h0, "R1 unmapped reads 0", int'(d), 0);

        // R2: control fields (free-run off, so no run starts)
        bus_write(5'h00, 32'h0C00_ABCD);
        bus_read(5'h00, d); check(d == 32'h0C00_ABCD, "R2 ctrl readback", int'(d), 32'h0C00_ABCD);
        bus_write(5'h00, 32'hFFFF_FFFF);
        bus_read(5'h00, d); check(d == 32'h0DFF_FFFF, "R2 ctrl unused bits", int'(d), 32'h0DFF_FFFF);
        // R8: start set with free-run off
        repeat (200) @(negedge clk);
        bus_read(5'h10, d); check(d == 32'h0, "R8 no valid without free-run", int'(d), 0);
        bus_write(5'h00, 32'h0);

        // R3: valid bit not writable
        bus_write(5'h10, 32'h0000_0101);
        bus_read(5'h10, d); check(d == 32'h0000_0100, "R3 valid bit read-only", int'(d), 32'h100);

        // R9: zero window
        bus_write(5'h00, ctrl_word(0, 0, 1'b1));
        repeat (200) @(negedge clk);
        bus_read(5'h10, d); check(d[0] == 1'b0, "R9 zero window no valid", int'(d[0]), 0);
        bus_write(5'h00, 32'h0);

        // R4/R5: channels with full windows
        measure(0, 1024, "R4 count ch0");
        measure(1, 1024, "R5 count ch1");
        measure(2, 1024, "R5 count ch2");
        measure(3, 1024, "R5 count ch3");
        measure(0, 8, "R4 short window");
        measure(2, 300, "R4 mid window");

        // R7: abort mid-run then restart
        bus_write(5'h00, ctrl_word(3, 1024, 1'b1));
        repeat (300) @(negedge clk);
        bus_read(5'h10, d); check(d[0] == 1'b0, "R10 mid-window no valid", int'(d[0]), 0);
        bus_write(5'h00, ctrl_word(3, 1024, 1'b0));
        bus_read(5'h10, d); check(d[0] == 1'b0, "R7 abort idle", int'(d[0]), 0);
        repeat (10) @(negedge clk);
        measure(3, 1024, "R7 restart count");

        while (act_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        run_done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule